// File: doc/BRIEF.md
# Converter Reset Sequencer

This block pulses the reset of a downstream video format converter and lets it go only at a safe place in the video line. It runs on the pixel clock. A start request makes it set the reset bit in the converter's control register. It then waits for the horizontal timing pulse to go from high to low. After that edge it removes the reset on the first start-of-active-video marker.

Both register accesses are read-modify-writes through a plain register port. The block drives a fixed address and reads the current contents combinationally on the read-data input. It changes only the reset bit and writes every other bit back unchanged.

A cycle budget starts at the horizontal falling edge. If no start-of-active-video marker arrives inside that budget, the block still releases the converter. In that case it raises a sticky timing-violation flag instead of the done pulse.

Top module: `conv_reset_seq`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, reg_we_o, done_o and viol_o are 0. A reset in the middle of a sequence returns the block to idle, and a later sav_i pulse causes no write.
- R2: When start_i is high in idle, the next cycle drives reg_we_o=1 with reg_addr_o=0x05E and reset bit 3 of reg_wdata_o set to 1.
- R3: On both writes, every bit of reg_wdata_o other than bit 3 equals the same bit of reg_rdata_i in that cycle.
- R4: Only a falling edge of hpulse_i (high in one cycle, low in the next) that falls after the set write cycle counts. An edge that coincides with the set write, a steady low level, and sav_i pulses before a counted edge cause no write.
- R5: After a counted edge, the release write (reg_we_o=1 with bit 3 of reg_wdata_o cleared) is driven combinationally in the first cycle in which sav_i is high, and in no earlier cycle.
- R6: done_o is high for exactly one cycle, the cycle after a release write that sav_i triggered.
- R7: The cycle after the counted edge is budget cycle 0. If sav_i is not high by budget cycle BUDGET-1 (1919 by default), the release write is forced in that cycle. viol_o rises in the next cycle and done_o stays low. A sav_i in budget cycle BUDGET-1 still counts as on time.
- R8: viol_o stays high once set, through later sequences, until rst_ni is asserted.
- R9: start_i is ignored while a sequence is in progress.
- R10: Each sequence drives exactly two write cycles: one set and one release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sequence request, sampled in idle |
| hpulse_i | input | 1 | Horizontal timing pulse |
| sav_i | input | 1 | Start-of-active-video marker |
| reg_rdata_i | input | DATA_W | Current contents of the control register |
| reg_addr_o | output | ADDR_W | Control register address (constant 0x05E) |
| reg_wdata_o | output | DATA_W | Write data |
| reg_we_o | output | 1 | Write strobe |
| done_o | output | 1 | One-cycle pulse after an on-time release |
| viol_o | output | 1 | Sticky budget-overrun flag |

## Verification
The assertions check on every cycle that:
- writes keep the bits other than the reset bit;
- a set write is never followed directly by another write;
- done only ever follows a release write and lasts one cycle;
- the budget counter stays in range;
- the violation flag never drops and only rises after a forced release.

Other behaviour can only be shown by the bench's scenarios:
- edge qualification, that is, which hpulse_i edges count;
- the exact cycle of the release against sav_i, including the last-budget-cycle boundary on both sides;
- that start requests are ignored while a sequence runs;
- the number of writes in each sequence.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SET,
    ST_WAIT_FALL,
    ST_WAIT_SAV,
    ST_DONE
  } crs_state_e;
endpackage

// File: rtl/crs_fall_detect.sv
module crs_fall_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic fall_o
);
  logic level_q;

  // reset low so no phantom edge right after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_i;
  end

  assign fall_o = level_q & ~level_i;
endmodule

// File: rtl/crs_budget_timer.sv
module crs_budget_timer #(
  parameter int LIMIT = 1920
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i)             cnt_q <= '0;
    else if (run_i && !last_o)    cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  assert_cnt_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !last_o && !clear_i) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/crs_rmw.sv
module crs_rmw #(
  parameter int DATA_W = 8,
  parameter int BIT    = 3
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              set_i,
  output logic [DATA_W-1:0] wdata_o
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(1) << BIT;

  assign wdata_o = set_i ? (rdata_i | MASK) : (rdata_i & ~MASK);
endmodule

// File: rtl/conv_reset_seq.sv
module conv_reset_seq
  import crs_pkg::*;
#(
  parameter int                ADDR_W    = 10,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 10'h05E,
  parameter int                RST_BIT   = 3,
  parameter int                BUDGET    = 1920
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              hpulse_i,
  input  logic              sav_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              done_o,
  output logic              viol_o
);
  localparam logic [DATA_W-1:0] KEEP = ~(DATA_W'(1) << RST_BIT);

  crs_state_e state_q, state_d;
  logic fall, last, release_now, viol_q;

  crs_fall_detect u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(hpulse_i),
    .fall_o (fall)
  );

  crs_budget_timer #(.LIMIT(BUDGET)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(state_q != ST_WAIT_SAV),
    .run_i  (state_q == ST_WAIT_SAV),
    .last_o (last)
  );

  crs_rmw #(.DATA_W(DATA_W), .BIT(RST_BIT)) u_rmw (
    .rdata_i(reg_rdata_i),
    .set_i  (state_q == ST_SET),
    .wdata_o(reg_wdata_o)
  );

  // release on SAV in the same cycle; forced at the budget end
  assign release_now = (state_q == ST_WAIT_SAV) && (sav_i || last);
  assign reg_we_o    = (state_q == ST_SET) || release_now;
  assign reg_addr_o  = CTRL_ADDR;
  assign done_o      = (state_q == ST_DONE);
  assign viol_o      = viol_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start_i) state_d = ST_SET;
      ST_SET:       state_d = ST_WAIT_FALL;
      ST_WAIT_FALL: if (fall) state_d = ST_WAIT_SAV;
      ST_WAIT_SAV:  if (sav_i) state_d = ST_DONE;
                    else if (last) state_d = ST_IDLE;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      viol_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WAIT_SAV && last && !sav_i) viol_q <= 1'b1;
    end
  end

  assert_rmw_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> ((reg_wdata_o ^ reg_rdata_i) & KEEP) == '0);

  assert_set_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_wdata_o[RST_BIT]) |=> !reg_we_o);

  assert_done_follows_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(reg_we_o && !reg_wdata_o[RST_BIT]));

  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_viol_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o);

  assert_viol_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(viol_o) |-> ($past(reg_we_o) && !done_o));
endmodule

// File: tb/conv_reset_seq_test.sv
module conv_reset_seq_test;
  localparam int          BUDGET = 1920;
  localparam logic [9:0]  CTRL   = 10'h05E;
  localparam logic [7:0]  BITM   = 8'h08;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       hpulse_i = 1'b0;
  logic       sav_i = 1'b0;
  logic [7:0] ctrl_val = 8'h00;
  logic [9:0] reg_addr_o;
  logic [7:0] reg_wdata_o;
  logic       reg_we_o, done_o, viol_o;
  int         n_tests = 0;
  int         n_fail = 0;
  int         wr_count = 0;

  always #2 clk_i = ~clk_i;

  conv_reset_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .hpulse_i(hpulse_i),
    .sav_i(sav_i), .reg_rdata_i(ctrl_val), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .reg_we_o(reg_we_o), .done_o(done_o), .viol_o(viol_o)
  );

  always @(posedge clk_i) if (rst_ni && reg_we_o) wr_count <= wr_count + 1;

  function automatic logic [7:0] set_val(input logic [7:0] v); return v | BITM; endfunction
  function automatic logic [7:0] clr_val(input logic [7:0] v); return v & ~BITM; endfunction

  task automatic tick; @(negedge clk_i); endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_seq(input logic [7:0] init, input int pre_wait, input int sav_wait,
                         input bit early, input bit hold_start, input logic exp_viol);
    int w0;
    ctrl_val = init; hpulse_i = 1'b1; tick;
    w0 = wr_count;
    start_i = 1'b1;
    if (early) hpulse_i = 1'b0;
    tick;
    check("R2 set strobe", reg_we_o, 1);
    check("R2 address", reg_addr_o, CTRL);
    check("R3 set data", reg_wdata_o, set_val(init));
    start_i = hold_start;
    tick;
    ctrl_val = set_val(init);
    for (int i = 0; i < pre_wait; i++) begin
      sav_i = 1'($urandom_range(0, 1));
      #1 check("R4 no write before counted edge", reg_we_o, 0);
      tick;
    end
    sav_i = 1'b0; hpulse_i = 1'b1; tick;
    hpulse_i = 1'b0; tick;
    for (int i = 0; i < sav_wait; i++) begin
      #1 check("R5 no release before sav", reg_we_o, 0);
      tick;
    end
    sav_i = 1'b1; start_i = 1'b0;
    #1 check("R5 release strobe", reg_we_o, 1);
    check("R3 release data", reg_wdata_o, clr_val(set_val(init)));
    tick;
    sav_i = 1'b0;
    ctrl_val = clr_val(init);
    check("R6 done pulse", done_o, 1);
    check("R6 no write with done", reg_we_o, 0);
    check("R8 viol level", viol_o, exp_viol);
    tick;
    check("R6 done one cycle", done_o, 0);
    if (hold_start) check("R9 busy start ignored, writes", wr_count - w0, 2);
    else            check("R10 two writes", wr_count - w0, 2);
  endtask

  task automatic run_timeout(input logic [7:0] init);
    int w0;
    ctrl_val = init; hpulse_i = 1'b1; tick;
    w0 = wr_count;
    start_i = 1'b1; tick;
    start_i = 1'b0; tick;
    ctrl_val = set_val(init);
    hpulse_i = 1'b0; tick;
    for (int m = 0; m < BUDGET - 2; m++) tick;
    #1 check("R7 no write before budget end", reg_we_o, 0);
    tick;
    #1 check("R7 forced release", reg_we_o, 1);
    check("R7 forced data", reg_wdata_o, clr_val(set_val(init)));
    check("R7 viol not yet", viol_o, 0);
    tick;
    ctrl_val = clr_val(init);
    check("R7 viol raised", viol_o, 1);
    check("R7 no done", done_o, 0);
    check("R7 writes", wr_count - w0, 2);
    tick;
    check("R8 viol sticky idle", viol_o, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick; tick;
    check("R1 reset we", reg_we_o, 0);
    check("R1 reset done", done_o, 0);
    check("R1 reset viol", viol_o, 0);
    rst_ni = 1'b1; tick;
    check("R1 after reset we", reg_we_o, 0);
    check("R1 after reset done", done_o, 0);

    run_seq(8'hF7, 3, 0, 1'b0, 1'b0, 1'b0);
    run_seq(8'h00, 0, 5, 1'b1, 1'b0, 1'b0);
    run_seq(8'hA5, 4, 7, 1'b0, 1'b1, 1'b0);
    run_seq(8'h5A, 2, BUDGET - 1, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 20; k++)
      run_seq(8'($urandom), $urandom_range(0, 20), $urandom_range(0, 300),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b0);

    run_timeout(8'h3C);
    run_seq(8'hC3, 1, 10, 1'b0, 1'b0, 1'b1);

    hpulse_i = 1'b1; start_i = 1'b1; tick;
    start_i = 1'b0; tick; tick;
    hpulse_i = 1'b0; tick; tick; tick;
    rst_ni = 1'b0;
    #1 check("R1 mid reset we", reg_we_o, 0);
    check("R1 mid reset viol cleared", viol_o, 0);
    tick;
    rst_ni = 1'b1; tick;
    sav_i = 1'b1;
    #1 check("R1 idle after reset, no write", reg_we_o, 0);
    tick;
    sav_i = 1'b0;
    check("R1 idle no done", done_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule